// File: doc/BRIEF.md
# Expansion Bus Bridge with Dynamic Port Sizing

This block connects a 32-bit CPU-side request port to an external expansion bus. A request is accepted only if its address falls inside a 2 MB window. The block then drives the address, data, direction and a cycle strobe onto the external bus. Every access begins as a full-word cycle. Only when the peripheral terminates that cycle does the bridge learn the peripheral's port width. The peripheral reports it through the code it places on two acknowledge lines.

If the peripheral reports a byte-wide port, the bridge moves the rest of the word in follow-up cycles. Each follow-up cycle uses the next external address. On reads the returned bytes are packed into one 32-bit word. On writes the bytes are presented one after another on the top byte lane. Because the width is learned per access, a byte-wide and a word-wide peripheral can answer at the same address with the same control lines. A later word-wide card can therefore stand in for an older byte-wide one.

If a peripheral never answers, a watchdog ends the request with an error. Outside of accepted requests the external lines are held still.

Top module: `exp_bridge`

## Requirements
- R1: A request (`req_valid` high) is accepted only when the bridge is idle and `req_addr[31:21]` equals the window base bits (default base 0x0080_0000). A request outside the window raises neither `req_busy` nor `xb_strobe` and produces no completion.
- R2: Every accepted request first runs one external cycle on the full 32-bit data bus, with `xb_addr` equal to `req_addr[20:0]`. An acknowledge code of 2'b11 completes the request after that single cycle. On reads, `req_rdata` then equals the full `xb_rdata` word.
- R3: The acknowledge code 2'b10 is handled exactly like 2'b11: one cycle, full-word transfer.
- R4: The acknowledge code 2'b01 marks a byte-wide port. The request then takes exactly four external cycles, at external addresses A, A+1, A+2 and A+3. `xb_strobe` is low for at least one clock between two of these cycles.
- R5: For byte-wide reads, the byte on `xb_rdata[31:24]` in cycle k (k = 0..3) lands in `req_rdata[31-8k -: 8]`, so the first byte becomes the most significant one. The lower 24 lanes are ignored.
- R6: For byte-wide writes, cycle k carries byte k of `req_wdata` on `xb_wdata[31:24]`, counting from the most significant byte.
- R7: `req_done` is a single-clock pulse. It is asserted on the clock after the edge that samples the final acknowledge. `req_busy` is high from the acceptance edge until the edge that raises `req_done` or `req_error`.
- R8: If `xb_strobe` stays high for 255 clocks with `xb_ack` = 2'b00, the bridge pulses `req_error` instead of `req_done`, drops `xb_strobe` and returns to idle. It then accepts new requests.
- R9: While `req_busy` is low, `xb_strobe` is low, and `xb_addr`, `xb_wdata` and `xb_write` do not change.
- R10: A request presented while `req_busy` is high is ignored and does not alter the request in progress.
- R11: While `xb_ack` is 2'b00 the bridge holds the current cycle. With an acknowledge latency of L clocks after the strobe rises, `req_done` is seen L+2 clocks after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | CPU-side request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | CPU byte address |
| req_wdata | input | 32 | Write word |
| req_busy | output | 1 | Request in progress |
| req_done | output | 1 | One-clock completion pulse |
| req_error | output | 1 | One-clock timeout pulse |
| req_rdata | output | 32 | Assembled read word, valid with `req_done` |
| xb_addr | output | 21 | External byte address |
| xb_wdata | output | 32 | External write data |
| xb_write | output | 1 | External direction, 1 = write |
| xb_strobe | output | 1 | External cycle active |
| xb_rdata | input | 32 | External read data |
| xb_ack | input | 2 | Termination code: 00 wait, 01 byte port, 10/11 word port |

## Verification
The bench reuses one address for a word-wide peripheral and a byte-wide one. A bridge that fixed the width at decode time, instead of at termination, would return a word with three garbage bytes or run stray cycles. Byte-wide reads and writes use distinct bytes. A wrong byte order, a missing address increment or a lost strobe gap would show up as scrambled data or repeated addresses. The reserved code 2'b10 is tested on its own, so a bridge that treated it as narrow would run four cycles.

A silent peripheral checks that the error arrives after exactly 255 strobe clocks and that the bridge can be reused afterwards. A second request arriving mid-transfer must not disturb the running byte sequence. An out-of-window request must leave the bus untouched.

// File: rtl/exp_bridge_pkg.sv
package exp_bridge_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_GAP  = 2'd2
  } br_state_t;

  localparam logic [1:0] ACK_WAIT = 2'b00;
  localparam logic [1:0] ACK_BYTE = 2'b01;

endpackage

// File: rtl/exp_window_decode.sv
module exp_window_decode #(
  parameter int CPU_ADDR_W = 32,
  parameter int WIN_ADDR_W = 21,
  parameter logic [CPU_ADDR_W-1:0] WIN_BASE = 32'h0080_0000
) (
  input  logic [CPU_ADDR_W-1:0] addr,
  output logic                  hit
);
  always_comb
    hit = (addr[CPU_ADDR_W-1:WIN_ADDR_W] == WIN_BASE[CPU_ADDR_W-1:WIN_ADDR_W]);
endmodule

// File: rtl/exp_ack_decode.sv
module exp_ack_decode
  import exp_bridge_pkg::*;
(
  input  logic [1:0] ack,
  output logic       ack_any,
  output logic       ack_narrow
);
  always_comb begin
    ack_any    = (ack != ACK_WAIT);
    ack_narrow = (ack == ACK_BYTE);
  end
endmodule

// File: rtl/exp_wait_timer.sv
module exp_wait_timer #(
  parameter int TIMEOUT = 255
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(TIMEOUT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (run)     cnt <= cnt + 1'b1;
  end

  always_comb expired = run && (cnt == CW'(TIMEOUT - 1));
endmodule

// File: rtl/exp_bridge.sv
module exp_bridge
  import exp_bridge_pkg::*;
#(
  parameter int CPU_ADDR_W = 32,
  parameter int WIN_ADDR_W = 21,
  parameter int DATA_W     = 32,
  parameter logic [CPU_ADDR_W-1:0] WIN_BASE = 32'h0080_0000,
  parameter int TIMEOUT    = 255
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [CPU_ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  req_busy,
  output logic                  req_done,
  output logic                  req_error,
  output logic [DATA_W-1:0]     req_rdata,
  output logic [WIN_ADDR_W-1:0] xb_addr,
  output logic [DATA_W-1:0]     xb_wdata,
  output logic                  xb_write,
  output logic                  xb_strobe,
  input  logic [DATA_W-1:0]     xb_rdata,
  input  logic [1:0]            xb_ack
);
  localparam int BYTES = DATA_W / 8;
  localparam int IDX_W = $clog2(BYTES);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BYTES - 1);

  br_state_t             st;
  logic                  hit, ack_any, ack_narrow, expired;
  logic                  narrow_q;
  logic [IDX_W-1:0]      idx;
  logic [DATA_W-1:0]     word_q;

  exp_window_decode #(
    .CPU_ADDR_W (CPU_ADDR_W),
    .WIN_ADDR_W (WIN_ADDR_W),
    .WIN_BASE   (WIN_BASE)
  ) u_dec (
    .addr (req_addr),
    .hit  (hit)
  );

  exp_ack_decode u_ack (
    .ack        (xb_ack),
    .ack_any    (ack_any),
    .ack_narrow (ack_narrow)
  );

  exp_wait_timer #(.TIMEOUT(TIMEOUT)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .clear   (!xb_strobe),
    .run     (xb_strobe && !ack_any),
    .expired (expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      req_busy  <= 1'b0;
      req_done  <= 1'b0;
      req_error <= 1'b0;
      req_rdata <= '0;
      xb_addr   <= '0;
      xb_wdata  <= '0;
      xb_write  <= 1'b0;
      xb_strobe <= 1'b0;
      narrow_q  <= 1'b0;
      idx       <= '0;
      word_q    <= '0;
    end else begin
      req_done  <= 1'b0;
      req_error <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_valid && hit) begin
            req_busy  <= 1'b1;
            xb_strobe <= 1'b1;
            xb_write  <= req_write;
            xb_addr   <= req_addr[WIN_ADDR_W-1:0];
            word_q    <= req_wdata;
            if (req_write) xb_wdata <= req_wdata;
            else           req_rdata <= '0;
            narrow_q  <= 1'b0;
            idx       <= '0;
            st        <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (expired) begin
            xb_strobe <= 1'b0;
            req_busy  <= 1'b0;
            req_error <= 1'b1;
            st        <= ST_IDLE;
          end else if (ack_any) begin
            xb_strobe <= 1'b0;
            if (!narrow_q && !ack_narrow) begin
              if (!xb_write) req_rdata <= xb_rdata;
              req_done <= 1'b1;
              req_busy <= 1'b0;
              st       <= ST_IDLE;
            end else begin
              narrow_q <= 1'b1;
              if (!xb_write)
                req_rdata[(BYTES-1-int'(idx))*8 +: 8] <= xb_rdata[DATA_W-1 -: 8];
              if (idx == IDX_LAST) begin
                req_done <= 1'b1;
                req_busy <= 1'b0;
                st       <= ST_IDLE;
              end else begin
                idx     <= idx + 1'b1;
                xb_addr <= xb_addr + 1'b1;
                if (xb_write)
                  xb_wdata[DATA_W-1 -: 8] <= word_q[(BYTES-2-int'(idx))*8 +: 8];
                st      <= ST_GAP;
              end
            end
          end
        end
        ST_GAP: begin
          xb_strobe <= 1'b1;
          st        <= ST_WAIT;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/exp_bridge_chk.sv
module exp_bridge_chk #(
  parameter int WIN_ADDR_W = 21,
  parameter int DATA_W     = 32,
  parameter int TIMEOUT    = 255
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req_busy,
  input logic                  req_done,
  input logic                  req_error,
  input logic [WIN_ADDR_W-1:0] xb_addr,
  input logic [DATA_W-1:0]     xb_wdata,
  input logic                  xb_write,
  input logic                  xb_strobe,
  input logic [1:0]            xb_ack
);
  int unsigned stall;

  always_ff @(posedge clk) begin
    if (rst || !xb_strobe || xb_ack != 2'b00) stall <= 0;
    else                                     stall <= stall + 1;
  end

  assert_idle_static_R9: assert property (@(posedge clk) disable iff (rst)
    !req_busy |-> ($stable(xb_addr) && $stable(xb_wdata) && $stable(xb_write)));

  assert_idle_no_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    !req_busy |-> !xb_strobe);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    req_done |=> !req_done);

  assert_end_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(req_done && req_error));

  assert_end_clears_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (req_done || req_error) |-> !req_busy);

  assert_accept_strobes_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(req_busy) |-> xb_strobe);

  assert_stall_bound_R8: assert property (@(posedge clk) disable iff (rst)
    stall <= TIMEOUT);
endmodule

bind exp_bridge exp_bridge_chk #(
  .WIN_ADDR_W (WIN_ADDR_W),
  .DATA_W     (DATA_W),
  .TIMEOUT    (TIMEOUT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_busy  (req_busy),
  .req_done  (req_done),
  .req_error (req_error),
  .xb_addr   (xb_addr),
  .xb_wdata  (xb_wdata),
  .xb_write  (xb_write),
  .xb_strobe (xb_strobe),
  .xb_ack    (xb_ack)
);

// File: tb/sim_exp_bridge.sv
`timescale 1ns/1ps
module sim_exp_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_busy, req_done, req_error;
  logic [31:0] req_rdata;
  logic [20:0] xb_addr;
  logic [31:0] xb_wdata;
  logic        xb_write, xb_strobe;
  logic [31:0] xb_rdata = '0;
  logic [1:0]  xb_ack = 2'b00;

  int checks = 0, errors = 0, cyc = 0;

  always #5 clk = ~clk;

  exp_bridge u0 (.*);

  // peripheral model: 0 silent, 1 byte port, 2 word port (11), 3 word port (10)
  int          dev = 2, lat = 0, wait_cnt = 0, n_cyc = 0, strobe_hi = 0;
  logic [20:0] log_addr [0:7];
  logic [7:0]  mem8 [0:15];
  logic [31:0] mem32 = 32'hCAFE_F00D;

  always @(negedge clk) begin
    if (xb_strobe) begin
      strobe_hi++;
      if (dev != 0 && wait_cnt == lat) begin
        if (n_cyc < 8) log_addr[n_cyc] = xb_addr;
        n_cyc++;
        if (dev == 1) begin
          xb_ack = 2'b01;
          if (xb_write) mem8[xb_addr[3:0]] = xb_wdata[31:24];
          else          xb_rdata = {mem8[xb_addr[3:0]], 24'hA5A5A5};
        end else begin
          xb_ack = (dev == 2) ? 2'b11 : 2'b10;
          if (xb_write) mem32 = xb_wdata;
          else          xb_rdata = mem32;
        end
      end else xb_ack = 2'b00;
      wait_cnt++;
    end else begin
      xb_ack = 2'b00;
      wait_cnt = 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // issue a request, follow it to its end; optional intruding request at busy cycle 2
  task automatic run_req(input bit wr, input logic [31:0] a, input logic [31:0] d, input bit intrude,
                         output logic [31:0] rd, output int dones, output int errs,
                         output int end_cyc, output bit busy_gap);
    int idle_tail;
    dones = 0; errs = 0; end_cyc = 0; busy_gap = 0; idle_tail = 0;
    n_cyc = 0; strobe_hi = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    for (int i = 1; i < 400; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (intrude && i == 2) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = a + 32'h40; req_wdata = 32'h0;
      end
      if (req_done)  begin dones++; if (end_cyc == 0) end_cyc = i; rd = req_rdata; end
      if (req_error) begin errs++;  if (end_cyc == 0) end_cyc = i; end
      if (end_cyc == 0 && !req_busy) busy_gap = 1;
      if (end_cyc != 0) begin idle_tail++; if (idle_tail > 4) break; end
    end
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    check(!req_busy && !req_done && !req_error, "R7 reset outputs", {29'd0, req_busy, req_done, req_error}, 0);
    check(!xb_strobe, "R9 reset strobe", {31'd0, xb_strobe}, 0);
  endtask

  task automatic t_word_read();
    logic [31:0] rd; int dn, er, ec; bit gap;
    dev = 2; lat = 2;
    run_req(0, 32'h0080_0124, 0, 0, rd, dn, er, ec, gap);
    check(rd == 32'hCAFE_F00D && dn == 1 && er == 0, "R2 word read data", rd, 32'hCAFE_F00D);
    check(n_cyc == 1 && log_addr[0] == 21'h000124, "R2 one cycle at address", {11'd0, log_addr[0]}, 32'h124);
    check(ec == lat + 2, "R11 latency to done", ec, lat + 2);
    check(!gap, "R7 busy held until done", gap, 0);
  endtask

  task automatic t_word_write_alt();
    logic [31:0] rd; int dn, er, ec; bit gap;
    dev = 3; lat = 0;
    run_req(1, 32'h0080_0124, 32'h1234_5678, 0, rd, dn, er, ec, gap);
    check(mem32 == 32'h1234_5678 && n_cyc == 1, "R3 code 10 is full word", mem32, 32'h1234_5678);
    check(dn == 1, "R3 single completion", dn, 1);
  endtask

  task automatic t_byte_read();
    logic [31:0] rd; int dn, er, ec; bit gap;
    dev = 1; lat = 1;
    mem8[4] = 8'h11; mem8[5] = 8'h22; mem8[6] = 8'h33; mem8[7] = 8'h44;
    run_req(0, 32'h0080_0124, 0, 0, rd, dn, er, ec, gap);
    check(n_cyc == 4, "R4 four byte cycles", n_cyc, 4);
    for (int k = 0; k < 4; k++)
      check(log_addr[k] == 21'h000124 + 21'(k), "R4 byte address", {11'd0, log_addr[k]}, 32'h124 + k);
    check(rd == 32'h1122_3344, "R5 packed read", rd, 32'h1122_3344);
    check(dn == 1 && !gap, "R7 one done after last byte", dn, 1);
  endtask

  task automatic t_byte_write();
    logic [31:0] rd; int dn, er, ec; bit gap;
    dev = 1; lat = 0;
    for (int k = 0; k < 16; k++) mem8[k] = 8'h00;
    run_req(1, 32'h0080_0128, 32'hDEAD_BEEF, 0, rd, dn, er, ec, gap);
    check({mem8[8], mem8[9], mem8[10], mem8[11]} == 32'hDEAD_BEEF, "R6 bytes msb first",
          {mem8[8], mem8[9], mem8[10], mem8[11]}, 32'hDEAD_BEEF);
    check(n_cyc == 4 && dn == 1, "R4 write four cycles", n_cyc, 4);
  endtask

  task automatic t_outside();
    logic [20:0] a0;
    a0 = xb_addr; n_cyc = 0; strobe_hi = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 32'h0060_0010; req_wdata = 32'h5555_AAAA;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 6; i++) begin
      check(!req_busy && !req_done, "R1 outside window ignored", req_busy, 0);
      @(negedge clk);
    end
    check(strobe_hi == 0 && xb_addr == a0, "R9 bus untouched when idle", {11'd0, xb_addr}, {11'd0, a0});
  endtask

  task automatic t_intrude();
    logic [31:0] rd; int dn, er, ec; bit gap;
    dev = 1; lat = 3;
    mem8[0] = 8'hA1; mem8[1] = 8'hB2; mem8[2] = 8'hC3; mem8[3] = 8'hD4;
    run_req(0, 32'h0080_0000, 0, 1, rd, dn, er, ec, gap);
    check(rd == 32'hA1B2_C3D4 && dn == 1, "R10 request while busy ignored", rd, 32'hA1B2_C3D4);
    check(n_cyc == 4 && log_addr[3] == 21'h3, "R10 sequence undisturbed", {11'd0, log_addr[3]}, 3);
    check(!xb_write, "R10 direction kept", xb_write, 0);
  endtask

  task automatic t_timeout();
    logic [31:0] rd; int dn, er, ec; bit gap;
    dev = 0;
    run_req(0, 32'h0080_0200, 0, 0, rd, dn, er, ec, gap);
    check(er == 1 && dn == 0, "R8 error instead of done", er, 1);
    check(strobe_hi == 255, "R8 strobe clocks before error", strobe_hi, 255);
    check(!xb_strobe && !req_busy, "R8 bus back to idle", xb_strobe, 0);
    dev = 2; lat = 0;
    run_req(0, 32'h0080_0200, 0, 0, rd, dn, er, ec, gap);
    check(dn == 1 && er == 0 && rd == mem32, "R8 usable after timeout", rd, mem32);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_word_read();
    t_word_write_alt();
    t_byte_read();
    t_byte_write();
    t_outside();
    t_intrude();
    t_timeout();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule